// File: doc/BRIEF.md
# Early-Completion Page Writer for Parallel EEPROM

This block is a bus master that sits on the host side of a byte-wide parallel EEPROM. A request names a start address and a byte count. The bytes then arrive one per handshake on a valid/ready stream. The block drives chip enable, write enable, output enable, the address and the data lines to load the bytes into the memory's page buffer. It then reads the last loaded location over and over until the memory reports that its internal programming has finished. It does not wait out a fixed worst-case programming time.

Completion is detected in one of two ways, chosen per request. In the first, bit 7 of the read-back byte is compared with bit 7 of the last byte written; a complemented bit 7 means the memory is still programming. In the second, bit 6 is expected to flip on every read while the memory is busy, so two consecutive reads with the same bit 6 mean it is done. Every request ends with a one-cycle done pulse. Error flags travel with that pulse and report a page overrun, a stalled stream or a poll timeout.

Top module: `eeprom_poll_writer`

## Requirements
- R1: A request is taken in a cycle where `req_valid` and `req_ready` are both high. `req_len_m1` encodes the byte count minus one, so a burst holds 1 to 2^PAGE_W bytes. `req_ready` is high only while the block is idle.
- R2: The page offset is the low PAGE_W address bits. If the offset plus the count exceeds 2^PAGE_W, the request overruns the page. With TRUNCATE=1 only the bytes up to the page end are written. With TRUNCATE=0 nothing is written. In both cases `err_page` is high during the closing done pulse.
- R3: Each byte is loaded by one write strobe. During the strobe `mem_we_n` stays low for exactly STROBE_CYC cycles, `mem_ce_n` is low, `mem_oe_n` is high and the data bus is driven. Address and data stay stable while `mem_we_n` is low.
- R4: Every byte of a burst goes to the next consecutive address. All strobes of a burst share the address bits above the page offset.
- R5: After the first byte, if no new stream byte arrives within STALL_MAX waiting cycles, the burst ends. The block polls the bytes loaded so far and flags `err_stall` at done. Write-enable falling edges of a burst are therefore never more than STROBE_CYC+1+STALL_MAX cycles apart.
- R6: Polling reads the last written address. Before `mem_oe_n` falls, the data bus has been released for at least one cycle with chip enable low. Each read holds `mem_oe_n` low for READ_CYC cycles.
- R7: With `req_toggle`=0, the request completes on the first read whose bit 7 equals bit 7 of the last written byte.
- R8: With `req_toggle`=1, the request completes on the first read whose bit 6 equals bit 6 of the read just before it.
- R9: If MAX_POLLS reads pass without completion, polling stops and `err_timeout` is high during the done pulse.
- R10: `done` is a single-cycle pulse that closes every accepted request. The error outputs are only high in that cycle.
- R11: After reset `mem_ce_n`, `mem_oe_n` and `mem_we_n` are high, the data bus is released, `req_ready` is high and `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | ADDR_W | Start address of the burst |
| req_len_m1 | input | PAGE_W | Byte count minus one |
| req_toggle | input | 1 | 1 selects bit-6 toggle detection, 0 selects bit-7 detection |
| dat_valid | input | 1 | Stream byte offered |
| dat_ready | output | 1 | Stream byte taken this cycle when valid |
| dat_byte | input | 8 | Stream byte |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq_out | output | 8 | Data driven to the memory |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | 8 | Data read from the memory |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| done | output | 1 | Request finished pulse |
| err_page | output | 1 | Page overrun, valid with done |
| err_stall | output | 1 | Stream stalled mid-burst, valid with done |
| err_timeout | output | 1 | Completion not seen, valid with done |

## Verification
The bench builds the block with a 6-bit address and 8-byte pages. Every start offset and every count can then be swept in both detection modes. This covers every overrun and truncation point along with the normal fits. Strobe and read lengths of two cycles, a stall limit of six and a poll limit of twenty keep the stall and timeout paths short. A behavioural memory in the bench stays busy for a chosen number of reads. A second instance built with TRUNCATE=0 covers the reject variant.

// File: rtl/eepw_pkg.sv
package eepw_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOAD,
      ST_WLO,
      ST_WHI,
      ST_PREP,
      ST_RLO,
      ST_FIN
   } eepw_state_e;

endpackage

// File: rtl/eepw_span.sv
module eepw_span #(
   parameter int PAGE_W   = 7,
   parameter bit TRUNCATE = 1'b1
) (
   input  logic [PAGE_W-1:0] ofs,
   input  logic [PAGE_W-1:0] len_m1,
   output logic [PAGE_W:0]   eff_cnt,
   output logic              over,
   output logic              reject
);
   localparam int CNT_W = PAGE_W + 1;

   logic [CNT_W-1:0] room;
   logic [CNT_W-1:0] want;

   assign room = {1'b1, {PAGE_W{1'b0}}} - {1'b0, ofs};
   assign want = {1'b0, len_m1} + CNT_W'(1);
   assign over = want > room;

   generate
      if (TRUNCATE) begin : g_clip
         assign eff_cnt = over ? room : want;
         assign reject  = 1'b0;
      end else begin : g_refuse
         assign eff_cnt = want;
         assign reject  = over;
      end
   endgenerate

endmodule

// File: rtl/eepw_status.sv
module eepw_status (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clear,
   input  logic       sample,
   input  logic       toggle_mode,
   input  logic [1:0] dq_hi,
   input  logic       ref7,
   output logic       hit
);
   logic prev6;
   logic have_prev;

   assign hit = toggle_mode ? (have_prev && (dq_hi[0] == prev6))
                            : (dq_hi[1] == ref7);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev6     <= 1'b0;
         have_prev <= 1'b0;
      end else if (clear) begin
         have_prev <= 1'b0;
      end else if (sample) begin
         prev6     <= dq_hi[0];
         have_prev <= 1'b1;
      end
   end

endmodule

// File: rtl/eeprom_poll_writer.sv
module eeprom_poll_writer
   import eepw_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int PAGE_W     = 7,
   parameter int STROBE_CYC = 4,
   parameter int READ_CYC   = 3,
   parameter int STALL_MAX  = 200,
   parameter int MAX_POLLS  = 100000,
   parameter bit TRUNCATE   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [PAGE_W-1:0] req_len_m1,
   input  logic              req_toggle,
   input  logic              dat_valid,
   output logic              dat_ready,
   input  logic [7:0]        dat_byte,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [7:0]        mem_dq_in,
   output logic              mem_ce_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic              done,
   output logic              err_page,
   output logic              err_stall,
   output logic              err_timeout
);
   localparam int CNT_W  = PAGE_W + 1;
   localparam int PG_W   = ADDR_W - PAGE_W;
   localparam int TMAX   = (STROBE_CYC > READ_CYC) ? STROBE_CYC : READ_CYC;
   localparam int TMR_W  = $clog2(TMAX + 1);
   localparam int WAIT_W = $clog2(STALL_MAX + 1);
   localparam int POLL_W = $clog2(MAX_POLLS + 1);

   generate
      if (PAGE_W < 1 || PAGE_W >= ADDR_W) begin : g_bad_page
         $error("PAGE_W must lie between 1 and ADDR_W-1");
      end
      if (STROBE_CYC < 1 || READ_CYC < 1) begin : g_bad_strobe
         $error("strobe lengths must be at least one cycle");
      end
      if (STALL_MAX < 1 || MAX_POLLS < 2) begin : g_bad_limit
         $error("STALL_MAX must be >= 1 and MAX_POLLS >= 2");
      end
   endgenerate

   eepw_state_e       state;
   logic [PG_W-1:0]   page_q;
   logic [PAGE_W-1:0] ofs_q;
   logic [CNT_W-1:0]  left_q;
   logic [7:0]        byte_q;
   logic [ADDR_W-1:0] last_addr;
   logic [7:0]        last_data;
   logic [TMR_W-1:0]  tmr;
   logic [WAIT_W-1:0] wait_q;
   logic [POLL_W-1:0] polls;
   logic              first_q;
   logic              mode_q;
   logic              f_page, f_stall, f_tmo;

   logic [CNT_W-1:0]  eff_cnt;
   logic              over, reject;
   logic              hit, sample;

   eepw_span #(.PAGE_W(PAGE_W), .TRUNCATE(TRUNCATE)) u_span (
      .ofs     (req_addr[PAGE_W-1:0]),
      .len_m1  (req_len_m1),
      .eff_cnt (eff_cnt),
      .over    (over),
      .reject  (reject)
   );

   assign sample = (state == ST_RLO) && (tmr == '0);

   eepw_status u_status (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear       (state == ST_IDLE),
      .sample      (sample),
      .toggle_mode (mode_q),
      .dq_hi       (mem_dq_in[7:6]),
      .ref7        (last_data[7]),
      .hit         (hit)
   );

   // pin decode from state
   always_comb begin
      req_ready = (state == ST_IDLE);
      dat_ready = (state == ST_LOAD);
      mem_ce_n  = 1'b1;
      mem_oe_n  = 1'b1;
      mem_we_n  = 1'b1;
      mem_dq_oe = 1'b0;
      mem_addr  = {page_q, ofs_q};
      unique case (state)
         ST_WLO:  begin mem_ce_n = 1'b0; mem_we_n = 1'b0; mem_dq_oe = 1'b1; end
         ST_WHI:  begin mem_ce_n = 1'b0; mem_dq_oe = 1'b1; end
         ST_PREP: begin mem_ce_n = 1'b0; mem_addr = last_addr; end
         ST_RLO:  begin mem_ce_n = 1'b0; mem_oe_n = 1'b0; mem_addr = last_addr; end
         default: ;
      endcase
   end

   assign mem_dq_out  = byte_q;
   assign done        = (state == ST_FIN);
   assign err_page    = done && f_page;
   assign err_stall   = done && f_stall;
   assign err_timeout = done && f_tmo;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         page_q    <= '0;
         ofs_q     <= '0;
         left_q    <= '0;
         byte_q    <= '0;
         last_addr <= '0;
         last_data <= '0;
         tmr       <= '0;
         wait_q    <= '0;
         polls     <= '0;
         first_q   <= 1'b0;
         mode_q    <= 1'b0;
         f_page    <= 1'b0;
         f_stall   <= 1'b0;
         f_tmo     <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: if (req_valid) begin
               mode_q  <= req_toggle;
               page_q  <= req_addr[ADDR_W-1:PAGE_W];
               ofs_q   <= req_addr[PAGE_W-1:0];
               left_q  <= eff_cnt;
               f_page  <= over;
               f_stall <= 1'b0;
               f_tmo   <= 1'b0;
               first_q <= 1'b1;
               wait_q  <= '0;
               polls   <= '0;
               state   <= reject ? ST_FIN : ST_LOAD;
            end
            ST_LOAD: if (dat_valid) begin
               byte_q <= dat_byte;
               tmr    <= TMR_W'(STROBE_CYC - 1);
               state  <= ST_WLO;
            end else if (!first_q) begin
               if (wait_q == WAIT_W'(STALL_MAX - 1)) begin
                  f_stall <= 1'b1;
                  state   <= ST_PREP;
               end else begin
                  wait_q <= wait_q + 1'b1;
               end
            end
            ST_WLO: if (tmr == '0) state <= ST_WHI;
                    else tmr <= tmr - 1'b1;
            ST_WHI: begin
               last_addr <= {page_q, ofs_q};
               last_data <= byte_q;
               ofs_q     <= ofs_q + 1'b1;
               left_q    <= left_q - 1'b1;
               first_q   <= 1'b0;
               wait_q    <= '0;
               state     <= (left_q == CNT_W'(1)) ? ST_PREP : ST_LOAD;
            end
            ST_PREP: begin
               tmr   <= TMR_W'(READ_CYC - 1);
               state <= ST_RLO;
            end
            ST_RLO: if (tmr == '0) begin
               polls <= polls + 1'b1;
               if (hit) begin
                  state <= ST_FIN;
               end else if (polls == POLL_W'(MAX_POLLS - 1)) begin
                  f_tmo <= 1'b1;
                  state <= ST_FIN;
               end else begin
                  state <= ST_PREP;
               end
            end else begin
               tmr <= tmr - 1'b1;
            end
            ST_FIN:  state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/eepw_checker.sv
module eepw_checker #(
   parameter int ADDR_W     = 16,
   parameter int PAGE_W     = 7,
   parameter int STROBE_CYC = 4,
   parameter int STALL_MAX  = 200
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [7:0]        mem_dq_out,
   input logic              mem_dq_oe,
   input logic              mem_ce_n,
   input logic              mem_oe_n,
   input logic              mem_we_n,
   input logic              done,
   input logic              req_ready
);
   localparam int GAP_LIM = STROBE_CYC + 1 + STALL_MAX;

   logic [15:0]              low_cnt;
   logic [15:0]              gap;
   logic                     in_burst;
   logic                     we_q;
   logic [ADDR_W-PAGE_W-1:0] page_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_cnt  <= '0;
         gap      <= '0;
         in_burst <= 1'b0;
         we_q     <= 1'b1;
         page_q   <= '0;
      end else begin
         we_q    <= mem_we_n;
         low_cnt <= mem_we_n ? 16'd0 : low_cnt + 16'd1;
         if (we_q && !mem_we_n) begin
            gap      <= 16'd1;
            in_burst <= 1'b1;
            page_q   <= mem_addr[ADDR_W-1:PAGE_W];
         end else begin
            if (gap != 16'hffff) gap <= gap + 16'd1;
            if (!mem_oe_n) in_burst <= 1'b0;
         end
      end
   end

   a_r3_we_width: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> low_cnt == 16'(STROBE_CYC));

   a_r3_write_drive: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> mem_dq_oe && mem_oe_n && !mem_ce_n);

   a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

   a_r4_same_page: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(mem_we_n) && in_burst) |-> mem_addr[ADDR_W-1:PAGE_W] == page_q);

   a_r5_load_gap: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(mem_we_n) && in_burst) |-> gap <= 16'(GAP_LIM));

   a_r6_bus_release: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_oe_n) |-> (!mem_dq_oe && $past(!mem_dq_oe) && $past(!mem_ce_n)));

   a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (mem_we_n && mem_oe_n && !mem_dq_oe));

endmodule

bind eeprom_poll_writer eepw_checker #(
   .ADDR_W     (ADDR_W),
   .PAGE_W     (PAGE_W),
   .STROBE_CYC (STROBE_CYC),
   .STALL_MAX  (STALL_MAX)
) u_eepw_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .mem_addr   (mem_addr),
   .mem_dq_out (mem_dq_out),
   .mem_dq_oe  (mem_dq_oe),
   .mem_ce_n   (mem_ce_n),
   .mem_oe_n   (mem_oe_n),
   .mem_we_n   (mem_we_n),
   .done       (done),
   .req_ready  (req_ready)
);

// File: tb/test_eeprom_poll_writer.sv
`timescale 1ns/1ps
module test_eeprom_poll_writer;
   localparam int AW = 6, PW = 3, SC = 2, RC = 2, SM = 6, MP = 20;
   localparam int PSZ = 1 << PW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   // main instance (truncating)
   logic          req_valid = 0, req_toggle = 0, dat_valid = 0;
   logic [AW-1:0] req_addr = '0;
   logic [PW-1:0] req_len_m1 = '0;
   logic [7:0]    dat_byte = '0;
   logic          req_ready, dat_ready, mem_dq_oe, mem_ce_n, mem_oe_n, mem_we_n;
   logic [AW-1:0] mem_addr;
   logic [7:0]    mem_dq_out;
   logic [7:0]    mem_dq_in = '0;
   logic          done, err_page, err_stall, err_timeout;

   eeprom_poll_writer #(.ADDR_W(AW), .PAGE_W(PW), .STROBE_CYC(SC), .READ_CYC(RC),
                        .STALL_MAX(SM), .MAX_POLLS(MP), .TRUNCATE(1'b1)) i_eeprom_poll_writer (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_len_m1(req_len_m1), .req_toggle(req_toggle),
      .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_byte(dat_byte),
      .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
      .mem_dq_in(mem_dq_in), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
      .done(done), .err_page(err_page), .err_stall(err_stall), .err_timeout(err_timeout));

   // reject variant
   logic          r_valid = 0;
   logic [AW-1:0] r_addr = '0;
   logic [PW-1:0] r_len = '0;
   logic          r_ready, r_dready, r_oe, r_ce_n, r_oe_n, r_we_n;
   logic [AW-1:0] r_maddr;
   logic [7:0]    r_dq_out;
   logic          r_done, r_epage, r_estall, r_etmo;

   eeprom_poll_writer #(.ADDR_W(AW), .PAGE_W(PW), .STROBE_CYC(SC), .READ_CYC(RC),
                        .STALL_MAX(SM), .MAX_POLLS(MP), .TRUNCATE(1'b0)) i_eeprom_poll_writer_rej (
      .clk(clk), .rst_n(rst_n), .req_valid(r_valid), .req_ready(r_ready),
      .req_addr(r_addr), .req_len_m1(r_len), .req_toggle(1'b0),
      .dat_valid(1'b0), .dat_ready(r_dready), .dat_byte(8'h00),
      .mem_addr(r_maddr), .mem_dq_out(r_dq_out), .mem_dq_oe(r_oe),
      .mem_dq_in(8'h00), .mem_ce_n(r_ce_n), .mem_oe_n(r_oe_n), .mem_we_n(r_we_n),
      .done(r_done), .err_page(r_epage), .err_stall(r_estall), .err_timeout(r_etmo));

   int n_chk = 0, n_fail = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // behavioural memory
   logic [7:0]    mem [PSZ*8];
   logic [AW-1:0] lat_a, last_a;
   logic [7:0]    last_d;
   int  wlow, wr_cnt, reads, busy, busy_cfg, bad_wr, bad_rd, r_wfall;
   bit  pend, tog, pwe = 1, poe = 1, rpwe = 1;

   always @(negedge clk) begin
      if (rst_n) begin
         if (pwe && !mem_we_n && !mem_ce_n) begin lat_a = mem_addr; wlow = 0; end
         if (!mem_we_n) wlow++;
         if (!pwe && mem_we_n) begin
            if (wlow != SC) bad_wr++;
            mem[lat_a] = mem_dq_out;
            last_a = lat_a; last_d = mem_dq_out; wr_cnt++; pend = 1;
         end
         if (poe && !mem_oe_n && !mem_ce_n) begin
            reads++;
            if (mem_dq_oe || mem_addr != last_a) bad_rd++;
            if (pend) begin busy = busy_cfg; pend = 0; end
            if (busy > 0) begin
               tog = ~tog; mem_dq_in = {~last_d[7], tog, 6'h15}; busy--;
            end else mem_dq_in = mem[mem_addr];
         end
         if (rpwe && !r_we_n) r_wfall++;
         pwe = mem_we_n; poe = mem_oe_n; rpwe = r_we_n;
      end
   end

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   function automatic logic [7:0] pat(input int off, input int cnt, input int i);
      return 8'(off * 37 + cnt * 11 + i * 73 + 5);
   endfunction

   bit g_done, g_pg, g_st, g_to;

   task automatic run(input int addr, input int cnt, input bit mode,
                      input int supply, input int b);
      busy_cfg = b; reads = 0; wr_cnt = 0; bad_wr = 0; bad_rd = 0; busy = 0; pend = 0;
      g_done = 0; g_pg = 0; g_st = 0; g_to = 0;
      @(negedge clk);
      req_valid = 1; req_addr = AW'(addr); req_len_m1 = PW'(cnt - 1); req_toggle = mode;
      @(negedge clk);
      req_valid = 0;
      chk(req_ready == 1'b0, "R1 ready low while busy", req_ready, 0);
      for (int k = 0; k < supply; k++) begin
         dat_valid = 1; dat_byte = pat(addr, cnt, k);
         while (!dat_ready) @(negedge clk);
         @(negedge clk);
      end
      dat_valid = 0;
      for (int t = 0; t < 3000; t++) begin
         if (done) begin
            g_done = 1; g_pg = err_page; g_st = err_stall; g_to = err_timeout;
            break;
         end
         @(negedge clk);
      end
      chk(g_done, "R10 done seen", g_done, 1);
      @(negedge clk);
      chk(done == 1'b0 && err_page == 1'b0, "R10 single cycle done", done, 0);
   endtask

   initial begin
      for (int a = 0; a < PSZ * 8; a++) mem[a] = 8'hEE;
      repeat (3) @(negedge clk);
      chk(mem_we_n && mem_oe_n && mem_ce_n, "R11 strobes idle in reset", {mem_we_n, mem_oe_n, mem_ce_n}, 7);
      chk(!mem_dq_oe && !done, "R11 bus released, no done", {mem_dq_oe, done}, 0);
      rst_n = 1;
      @(negedge clk);
      chk(req_ready == 1'b1, "R11 ready after reset", req_ready, 1);

      // sweep: both modes, all offsets, all counts
      for (int m = 0; m < 2; m++)
         for (int off = 0; off < PSZ; off++)
            for (int cnt = 1; cnt <= PSZ; cnt++) begin
               automatic int base = ((off + cnt + m) % 6) * PSZ;
               automatic int eff  = (off + cnt > PSZ) ? PSZ - off : cnt;
               automatic int b    = (off + cnt) % 4;
               automatic int bad  = 0;
               run(base + off, cnt, m[0], eff, b);
               chk(g_pg == (off + cnt > PSZ), "R2 page overrun flag", g_pg, off + cnt > PSZ);
               chk(wr_cnt == eff, "R2 bytes written", wr_cnt, eff);
               for (int i = 0; i < eff; i++)
                  if (mem[base + off + i] != pat(base + off, cnt, i)) bad++;
               chk(bad == 0, "R4 consecutive bytes in page", bad, 0);
               chk(bad_wr == 0, "R3 strobe width", bad_wr, 0);
               chk(bad_rd == 0, "R6 read address and release", bad_rd, 0);
               chk(!g_st && !g_to, "R9 no spurious errors", {g_st, g_to}, 0);
               if (m == 0)
                  chk(reads == b + 1, "R7 bit-7 completion read count", reads, b + 1);
               else
                  chk(reads >= b + 1 && reads <= b + 2, "R8 toggle completion read count", reads, b + 2);
            end

      // stall mid-burst
      run(16, 4, 1'b0, 1, 1);
      chk(g_st == 1'b1, "R5 stall flagged", g_st, 1);
      chk(wr_cnt == 1, "R5 one byte loaded", wr_cnt, 1);
      chk(reads == 2, "R5 polling after stall", reads, 2);

      // timeout in both modes
      run(40, 2, 1'b0, 2, 100);
      chk(g_to == 1'b1, "R9 timeout flag bit-7", g_to, 1);
      chk(reads == MP, "R9 poll limit bit-7", reads, MP);
      run(41, 1, 1'b1, 1, 100);
      chk(g_to == 1'b1, "R9 timeout flag toggle", g_to, 1);
      chk(reads == MP, "R9 poll limit toggle", reads, MP);

      // reject variant
      @(negedge clk);
      r_valid = 1; r_addr = 6'd6; r_len = 3'd3;
      @(negedge clk);
      r_valid = 0;
      chk(r_done && r_epage, "R2 reject with flag", {r_done, r_epage}, 3);
      repeat (4) @(negedge clk);
      chk(r_wfall == 0 && r_ready, "R2 rejected request writes nothing", r_wfall, 0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule